// File: doc/BRIEF.md
# Calibration Pulse Rate Scaler

This block turns a stream of real-power samples into a fast calibration pulse train. Every accepted sample is added to an accumulator. When the accumulator reaches a trip level, that level is subtracted from it and one output pulse is issued. The trip level is a base level divided by a rate multiplier. A 3-bit mode word (a scale-select bit and two rate-select bits) chooses the multiplier. The multiplier ranges from 16 to 2048, so the pulse count always stays an exact multiple of what the slow-rate path would produce from the same samples.

Samples below a no-load floor are dropped, so a meter with no load does not creep. The output pulse is active high. Its width depends on the mode and on the spacing of the pulses. In the high-rate mode the width is a short fixed value. In every other mode the width is a long fixed value when pulses are far apart, and half the measured spacing when they are close. Any change of the mode word restarts the block from a clean state.

Top module: `cal_pulse_scaler`

## Requirements
- R1: After reset `cfOut` is low, and it stays low until a sample crosses the trip level.
- R2: The mode word is {scfSel, rateSel[1], rateSel[0]}. Its multiplier is 128 for 100, 64 for 000 and 101, 32 for 001 and 110, 16 for 010 and 111, and 2048 for 011. The trip level is BASE_THRESH divided by the multiplier. Each time the running sum of accepted samples reaches the trip level, one pulse is issued and the trip level is removed from the sum. `cfOut` rises in the cycle after the clock edge that accepts the crossing sample.
- R3: A sample is ignored when `sampleValid` is low or when `sample` is below CREEP_MIN. A sample equal to CREEP_MIN is counted.
- R4: Outside mode 011, the pulse is LONG_WIDTH cycles wide when the spacing from the previous pulse start is at least 2*LONG_WIDTH cycles. The same width is used when no pulse has started since reset or since the last mode change.
- R5: Outside mode 011, when the spacing from the previous pulse start is P < 2*LONG_WIDTH cycles, the pulse is max(1, floor(P/2)) cycles wide.
- R6: In mode 011, every pulse is FAST_WIDTH cycles wide, whatever the rate.
- R7: A change of the mode word clears the accumulator, drops the sample presented at that edge, ends any pulse in progress at that edge, and forgets the previous pulse spacing.
- R8: A crossing that occurs while `cfOut` is high keeps `cfOut` high and restarts the width timer with the width computed for the new spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| scfSel | input | 1 | Scale-select bit, the most significant bit of the mode word |
| rateSel | input | 2 | Rate-select bits, the low bits of the mode word |
| sampleValid | input | 1 | Qualifies `sample` in this cycle |
| sample | input | SAMPLE_W | Unsigned real-power sample |
| cfOut | output | 1 | Active-high calibration pulse |

## Verification
The assertions assume that no single sample exceeds the trip level of the current mode, so at most one pulse falls due per sample. Under that assumption the accumulator always stays below the trip level. The stimulus respects this limit. In the high-rate mode the trip level is 32 and samples never exceed 4. In the other modes each sample is a whole fraction of the trip level, which also makes the pulse spacing an exact number of cycles. That exact spacing lets the bench predict both the pulse count and every pulse width arithmetically.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

  typedef logic [2:0] cfMode_t;

  typedef struct packed {
    logic clear;
    logic enable;
  } cfStrobes_t;

  localparam cfMode_t FAST_MODE = 3'b011;

  function automatic logic [3:0] modeShift(input cfMode_t m);
    logic [3:0] s;
    case (m)
      3'b100:          s = 4'd7;
      3'b000, 3'b101:  s = 4'd6;
      3'b001, 3'b110:  s = 4'd5;
      3'b010, 3'b111:  s = 4'd4;
      default:         s = 4'd11;
    endcase
    return s;
  endfunction

  function automatic logic isFastMode(input cfMode_t m);
    return m == FAST_MODE;
  endfunction

endpackage

// File: rtl/cfs_datapath.sv
module cfs_datapath
  import cfs_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int BASE_THRESH = 65536,
  parameter int CREEP_MIN   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  cfStrobes_t          strobes,
  input  cfMode_t             modeQ,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                crossing
);

  localparam int LOG_BASE = $clog2(BASE_THRESH);
  localparam int ACC_W    = ((LOG_BASE > SAMPLE_W) ? LOG_BASE : SAMPLE_W) + 2;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] thresh;
  logic             accepted;

  always_comb begin
    thresh   = ACC_W'(BASE_THRESH) >> modeShift(modeQ);
    accepted = strobes.enable && sampleValid && (sample >= SAMPLE_W'(CREEP_MIN));
    sum      = acc + ACC_W'(sample);
    crossing = accepted && (sum >= thresh);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0;
    end else if (strobes.clear) begin
      acc <= '0;
    end else if (accepted) begin
      acc <= crossing ? (sum - thresh) : sum;
    end
  end

  // R7
  acc_cleared_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> acc == '0);

  // R3
  creep_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && sample < SAMPLE_W'(CREEP_MIN) && !strobes.clear) |=> acc == $past(acc));

  // R2
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    acc < thresh);

endmodule

// File: rtl/cfs_control.sv
module cfs_control
  import cfs_pkg::*;
#(
  parameter int LONG_WIDTH = 40,
  parameter int FAST_WIDTH = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  cfMode_t    modeIn,
  input  logic       crossing,
  output cfMode_t    modeQ,
  output cfStrobes_t strobes,
  output logic       cf
);

  localparam int SAT   = 2 * LONG_WIDTH;
  localparam int CNT_W = $clog2(SAT + 1) + 1;

  logic [CNT_W-1:0] periodCnt;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] halfWidth;
  logic [CNT_W-1:0] newWidth;
  logic [CNT_W-1:0] left;
  logic             modeChange;

  always_comb begin
    modeChange     = modeIn != modeQ;
    strobes.clear  = modeChange;
    strobes.enable = !modeChange;
    period         = periodCnt + CNT_W'(1);
    halfWidth      = (period >> 1) == '0 ? CNT_W'(1) : (period >> 1);
    if (isFastMode(modeQ))
      newWidth = CNT_W'(FAST_WIDTH);
    else if (period >= CNT_W'(SAT))
      newWidth = CNT_W'(LONG_WIDTH);
    else
      newWidth = halfWidth;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ     <= '0;
      cf        <= 1'b0;
      left      <= '0;
      periodCnt <= CNT_W'(SAT - 1);
    end else if (modeChange) begin
      modeQ     <= modeIn;
      cf        <= 1'b0;
      left      <= '0;
      periodCnt <= CNT_W'(SAT - 1);
    end else begin
      if (crossing)
        periodCnt <= '0;
      else if (periodCnt < CNT_W'(SAT - 1))
        periodCnt <= periodCnt + CNT_W'(1);

      if (crossing) begin
        cf   <= 1'b1;
        left <= newWidth;
      end else if (cf) begin
        if (left <= CNT_W'(1)) begin
          cf   <= 1'b0;
          left <= '0;
        end else begin
          left <= left - CNT_W'(1);
        end
      end
    end
  end

  // R7
  mode_kill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeIn != modeQ) |=> !cf);

  // R6
  fast_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cf && isFastMode(modeQ)) |-> left <= CNT_W'(FAST_WIDTH));

  // R4
  long_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    cf |-> left <= CNT_W'(LONG_WIDTH));

endmodule

// File: rtl/cal_pulse_scaler.sv
module cal_pulse_scaler
  import cfs_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int BASE_THRESH = 65536,
  parameter int CREEP_MIN   = 4,
  parameter int LONG_WIDTH  = 40,
  parameter int FAST_WIDTH  = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                scfSel,
  input  logic [1:0]          rateSel,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                cfOut
);

  cfMode_t    modeQ;
  cfStrobes_t strobes;
  logic       crossing;

  cfs_control #(
    .LONG_WIDTH(LONG_WIDTH),
    .FAST_WIDTH(FAST_WIDTH)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .modeIn  ({scfSel, rateSel}),
    .crossing(crossing),
    .modeQ   (modeQ),
    .strobes (strobes),
    .cf      (cfOut)
  );

  cfs_datapath #(
    .SAMPLE_W   (SAMPLE_W),
    .BASE_THRESH(BASE_THRESH),
    .CREEP_MIN  (CREEP_MIN)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .modeQ      (modeQ),
    .sampleValid(sampleValid),
    .sample     (sample),
    .crossing   (crossing)
  );

endmodule

// File: tb/sim_cal_pulse_scaler.sv
module sim_cal_pulse_scaler;

  localparam int BASE  = 65536;
  localparam int LONGW = 40;
  localparam int FASTW = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        scfSel = 1'b0;
  logic [1:0]  rateSel = 2'b00;
  logic        sampleValid = 1'b0;
  logic [15:0] sample = '0;
  logic        cfOut;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  cal_pulse_scaler u0 (
    .clk(clk), .rstN(rstN), .scfSel(scfSel), .rateSel(rateSel),
    .sampleValid(sampleValid), .sample(sample), .cfOut(cfOut)
  );

  // pulse monitor, sampled away from the active edge
  int   riseCount = 0;
  int   runIdx = 0;
  int   run = 0;
  int   runLen [8];
  logic prevCf = 1'b0;

  always @(negedge clk) begin
    if (cfOut && !prevCf) begin
      riseCount <= riseCount + 1;
      run <= 1;
    end else if (cfOut) begin
      run <= run + 1;
    end else if (prevCf) begin
      runLen[runIdx % 8] <= run;
      runIdx <= runIdx + 1;
    end
    prevCf <= cfOut;
  end

  function automatic int multOf(input logic [2:0] m);
    case (m)
      3'b100: return 128;
      3'b000, 3'b101: return 64;
      3'b001, 3'b110: return 32;
      3'b010, 3'b111: return 16;
      default: return 2048;
    endcase
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic setMode(input logic [2:0] m);
    {scfSel, rateSel} = m;
    sampleValid = 1'b0;
    idle(3);
  endtask

  task automatic feed(input int s, input int n);
    sampleValid = 1'b1;
    sample = 16'(s);
    repeat (n) @(posedge clk);
    #2;
    sampleValid = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
    $finish;
  end

  initial begin
    int r0, i0;
    idle(4);
    rstN = 1'b1;
    idle(2);
    @(negedge clk);
    check(cfOut == 1'b0, "R1 reset low", int'(cfOut), 0);
    idle(1);

    // R2 R4 R6: sweep every mode with exact-spacing stimulus
    for (int m = 0; m < 8; m++) begin
      int thr, s, p, n, expPulses, expW;
      setMode(3'(m));
      thr = BASE / multOf(3'(m));
      s   = (m == 3) ? 4 : thr / 128;
      p   = thr / s;
      n   = 1024;
      expPulses = n / p;
      expW = (m == 3) ? FASTW : LONGW;
      r0 = riseCount; i0 = runIdx;
      feed(s, n);
      idle(100);
      check(riseCount - r0 == expPulses, $sformatf("R2 mode%0d count", m), riseCount - r0, expPulses);
      check(runLen[i0 % 8] == expW, (m == 3) ? "R6 fast width first" : "R4 long width first",
            runLen[i0 % 8], expW);
      check(runLen[(runIdx - 1) % 8] == expW, (m == 3) ? "R6 fast width last" : "R4 long width last",
            runLen[(runIdx - 1) % 8], expW);
    end

    // R3 creep floor in mode 100 (trip 512)
    setMode(3'b100);
    r0 = riseCount;
    feed(3, 1000);
    idle(50);
    check(riseCount == r0, "R3 below floor no pulse", riseCount - r0, 0);
    feed(4, 128);
    idle(50);
    check(riseCount - r0 == 1, "R3 at floor counted", riseCount - r0, 1);
    sampleValid = 1'b0;

    // R5 half-period width, spacing 64
    setMode(3'b000);
    setMode(3'b100);
    r0 = riseCount; i0 = runIdx;
    feed(8, 256);
    idle(60);
    check(riseCount - r0 == 4, "R5 count", riseCount - r0, 4);
    check(runLen[i0 % 8] == LONGW, "R4 first pulse after clear", runLen[i0 % 8], LONGW);
    check(runLen[(i0 + 1) % 8] == 32, "R5 half width", runLen[(i0 + 1) % 8], 32);
    check(runLen[(i0 + 3) % 8] == 32, "R5 half width last", runLen[(i0 + 3) % 8], 32);

    // R8 retrigger while high: mode 001 trip 2048, spacing 32
    setMode(3'b001);
    r0 = riseCount; i0 = runIdx;
    feed(64, 64);
    idle(80);
    check(riseCount - r0 == 1, "R8 single rise", riseCount - r0, 1);
    check(runLen[i0 % 8] == 48, "R8 merged width", runLen[i0 % 8], 48);

    // R7 mode change clears accumulator
    setMode(3'b100);
    r0 = riseCount;
    feed(4, 100);
    setMode(3'b000);
    setMode(3'b100);
    feed(4, 28);
    idle(50);
    check(riseCount == r0, "R7 accumulator cleared", riseCount - r0, 0);
    feed(4, 100);
    idle(50);
    check(riseCount - r0 == 1, "R7 fresh count", riseCount - r0, 1);

    // R7 mode change ends pulse in progress
    setMode(3'b000);
    setMode(3'b100);
    feed(4, 128);
    idle(3);
    @(negedge clk);
    check(cfOut == 1'b1, "R7 pulse running", int'(cfOut), 1);
    #8;
    {scfSel, rateSel} = 3'b101;
    @(posedge clk);
    @(negedge clk);
    check(cfOut == 1'b0, "R7 pulse killed", int'(cfOut), 0);
    idle(60);
    check(cfOut == 1'b0, "R7 stays low", int'(cfOut), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule